// File: doc/BRIEF.md
# Hardware Reset Pulse Filter

This block qualifies the active-low hardware reset pin of a managed flash device. The pin is sampled on a free-running reference clock of known period. Short glitches of either polarity are rejected. A level change is accepted only once the input has held its new value for a set number of reference cycles. That number sits between the narrowest pulse that must be ignored (5 ns) and the widest pulse that must always be seen (1 µs).

Each accepted rising edge of the filtered reset emits a one-cycle strobe that starts the internal reset sequence. The same edge arms two gates:

- a hold-off timer covering the minimum time before a command may be taken (200 µs by default);
- a counter of host bus clock rising edges, since the first initialisation command needs at least 74 bus clock cycles.

The command-ready flag rises only when both gates are complete. It drops on every accepted falling edge.

Top module: `rhf_reset_qualifier`

## Requirements
- R1: A pulse of either polarity that the synchronised input holds for fewer than FILT_CYCLES consecutive reference cycles never changes `filt_rst_n`.
- R2: A level held for FILT_CYCLES or more cycles is accepted. `filt_rst_n` takes the new value FILT_CYCLES+2 reference cycles after the input changes (two synchroniser flops plus the qualification count).
- R3: With the default parameters (4 ns reference period, FILT_CYCLES=16, so 64 ns), a 1-cycle glitch is rejected and a 250-cycle (1 µs) pulse is accepted.
- R4: `rst_start` is high for exactly one cycle, in the first cycle that `filt_rst_n` reads 1 after an accepted rising edge. It never pulses on a falling edge or on a rejected glitch.
- R5: `cmd_ready` is 0 in the same cycle that `filt_rst_n` first reads 0 after an accepted falling edge, and it stays 0 while `filt_rst_n` is 0.
- R6: `cmd_ready` rises no earlier than HOLDOFF_CYC+1 cycles after the `rst_start` cycle. HOLDOFF_CYC is ceil(HOLDOFF_NS*1000/REF_PERIOD_PS), which is 50000 cycles for 200 µs at 4 ns. When the bus clock gate is already complete, `cmd_ready` rises exactly at that point.
- R7: `cmd_ready` also waits for MIN_BUS_EDGES (default 74) rising edges of `bus_clk` seen after `rst_start`. If `bus_clk` is stopped, `cmd_ready` stays 0.
- R8: While `rst` is high, and in the first cycle after it, `filt_rst_n`, `rst_start` and `cmd_ready` are all 0.
- R9: Once set, `cmd_ready` stays 1 through any rejected glitch and only clears on an accepted falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| rst_n_in | input | 1 | Raw active-low hardware reset pin, asynchronous |
| bus_clk | input | 1 | Host bus clock, asynchronous, sampled for rising edges |
| filt_rst_n | output | 1 | Qualified reset level (0 = device held in reset) |
| rst_start | output | 1 | One-cycle strobe on each accepted rising edge |
| cmd_ready | output | 1 | High when the first initialisation command may be accepted |

## Verification
Pulses of both polarities are tried at widths just below the qualification count, exactly at it, and at the default-parameter extremes of one cycle and 1 µs. Together these separate an off-by-one in the qualifier from a correct one.

Randomly sized pulses on alternating base levels check that each accepted pulse gives two level changes and one strobe, and that each rejected one gives none.

The readiness flag is tried with three bus clock patterns:
- a fast bus clock, so the timer alone decides readiness;
- a slow bus clock, so the 74th edge decides it;
- a stopped bus clock, which proves that the two gates are ANDed rather than ORed.

// File: rtl/rhf_pkg.sv
package rhf_pkg;

    // Events produced by the width qualifier in one reference cycle.
    typedef struct packed {
        logic level;   // committed filtered level
        logic rise;    // committed 0->1 this cycle
        logic fall;    // committed 1->0 this cycle
    } rhf_filt_t;

    // Reference cycles covering a span given in ns, rounded up.
    function automatic int unsigned span_cycles(input longint unsigned span_ns,
                                                input longint unsigned period_ps);
        longint unsigned total_ps;
        total_ps = span_ns * 64'd1000;
        return int'((total_ps + period_ps - 64'd1) / period_ps);
    endfunction

    // Counter width able to hold values 0..limit.
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/rhf_sync.sv
module rhf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rhf_glitch_filter.sv
module rhf_glitch_filter
    import rhf_pkg::*;
#(
    parameter int unsigned FILT_CYCLES = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    output rhf_filt_t ev
);
    localparam int unsigned CW = cnt_width(FILT_CYCLES);

    logic [CW-1:0] run_cnt;
    rhf_filt_t     st;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            st      <= '0;
        end else begin
            st.rise <= 1'b0;
            st.fall <= 1'b0;
            if (din == st.level) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(FILT_CYCLES - 1)) begin
                run_cnt  <= '0;
                st.level <= din;
                st.rise  <= din;
                st.fall  <= ~din;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign ev = st;
endmodule

// File: rtl/rhf_span_counter.sv
module rhf_span_counter
    import rhf_pkg::*;
#(
    parameter int unsigned LIMIT = 74
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    input  logic en,
    output logic done
);
    localparam int unsigned CW = cnt_width(LIMIT);

    logic [CW-1:0] cnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            cnt   <= '0;
            armed <= 1'b0;
            done  <= 1'b0;
        end else if (start) begin
            cnt   <= '0;
            armed <= 1'b1;
            done  <= 1'b0;
        end else if (armed && en && !done) begin
            if (cnt == CW'(LIMIT - 1)) done <= 1'b1;
            else                       cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rhf_reset_qualifier.sv
module rhf_reset_qualifier
    import rhf_pkg::*;
#(
    parameter int unsigned REF_PERIOD_PS = 4000,
    parameter int unsigned FILT_CYCLES   = 16,
    parameter int unsigned HOLDOFF_NS    = 200000,
    parameter int unsigned MIN_BUS_EDGES = 74,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_n_in,
    input  logic bus_clk,
    output logic filt_rst_n,
    output logic rst_start,
    output logic cmd_ready
);
    localparam int unsigned HOLDOFF_CYC = span_cycles(HOLDOFF_NS, REF_PERIOD_PS);

    logic      rst_sync;
    logic      bus_sync;
    logic      bus_prev;
    logic      bus_rise;
    logic      timer_done;
    logic      edges_done;
    rhf_filt_t fev;

    rhf_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk(clk), .rst(rst), .d(rst_n_in), .q(rst_sync)
    );

    rhf_sync #(.STAGES(SYNC_STAGES)) u_bus_sync (
        .clk(clk), .rst(rst), .d(bus_clk), .q(bus_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) bus_prev <= 1'b0;
        else     bus_prev <= bus_sync;
    end
    assign bus_rise = bus_sync & ~bus_prev;

    rhf_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk(clk), .rst(rst), .din(rst_sync), .ev(fev)
    );

    rhf_span_counter #(.LIMIT(HOLDOFF_CYC)) u_holdoff (
        .clk(clk), .rst(rst), .start(fev.rise), .abort(fev.fall),
        .en(1'b1), .done(timer_done)
    );

    rhf_span_counter #(.LIMIT(MIN_BUS_EDGES)) u_bus_edges (
        .clk(clk), .rst(rst), .start(fev.rise), .abort(fev.fall),
        .en(bus_rise), .done(edges_done)
    );

    assign filt_rst_n = fev.level;
    assign rst_start  = fev.rise;
    assign cmd_ready  = fev.level & timer_done & edges_done;
endmodule

// File: rtl/rhf_reset_qualifier_chk.sv
module rhf_reset_qualifier_chk #(
    parameter int unsigned FILT_CYCLES = 16,
    parameter int unsigned HOLDOFF_CYC = 50000
) (
    input logic clk,
    input logic rst,
    input logic rst_sync,
    input logic filt_rst_n,
    input logic rst_start,
    input logic cmd_ready
);
    localparam int unsigned RW = $clog2(FILT_CYCLES + 2);
    localparam int unsigned SW = $clog2(HOLDOFF_CYC + 2);

    logic [RW-1:0] run_q;    // cycles the synchronised input has disagreed with the level
    logic [SW-1:0] since_q;  // cycles since the last start strobe, saturating

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            since_q <= '0;
        end else begin
            if (rst_sync == filt_rst_n)          run_q <= '0;
            else if (run_q != RW'(FILT_CYCLES))  run_q <= run_q + 1'b1;
            if (rst_start)                         since_q <= '0;
            else if (since_q != SW'(HOLDOFF_CYC))  since_q <= since_q + 1'b1;
        end
    end

    // R1 and R2: a level change only after FILT_CYCLES cycles of disagreement
    a_r1_change_needs_full_run: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_rst_n) |-> run_q == RW'(FILT_CYCLES));

    // R4: the strobe marks an accepted rising edge only
    a_r4_start_on_rise: assert property (@(posedge clk) disable iff (rst)
        rst_start |-> (filt_rst_n && $rose(filt_rst_n)));

    // R4: the strobe lasts one cycle
    a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
        rst_start |=> !rst_start);

    // R5: no readiness while the device is held in reset
    a_r5_ready_needs_level: assert property (@(posedge clk) disable iff (rst)
        !filt_rst_n |-> !cmd_ready);

    // R6: readiness respects the hold-off window
    a_r6_holdoff_elapsed: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> since_q >= SW'(HOLDOFF_CYC));

    // R9: readiness only drops together with the filtered level
    a_r9_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_ready) |-> $fell(filt_rst_n));
endmodule

bind rhf_reset_qualifier rhf_reset_qualifier_chk #(
    .FILT_CYCLES(FILT_CYCLES),
    .HOLDOFF_CYC(HOLDOFF_CYC)
) u_chk (
    .clk(clk),
    .rst(rst),
    .rst_sync(rst_sync),
    .filt_rst_n(filt_rst_n),
    .rst_start(rst_start),
    .cmd_ready(cmd_ready)
);

// File: tb/tb_rhf_reset_qualifier.sv
module tb_rhf_reset_qualifier;
    localparam int FILT  = 16;
    localparam int HNS   = 4000;            // shortened hold-off for the bench
    localparam int LIMIT = HNS * 1000 / 4000; // 1000 cycles at 4 ns
    localparam int EDGES = 74;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_n_in = 1'b0;
    logic bus_clk = 1'b0;
    logic filt_rst_n, rst_start, cmd_ready;

    int checks = 0;
    int failures = 0;
    int bus_half = 0;
    int bus_edges = 0;

    always #2 clk = ~clk;

    rhf_reset_qualifier #(
        .REF_PERIOD_PS(4000), .FILT_CYCLES(FILT), .HOLDOFF_NS(HNS),
        .MIN_BUS_EDGES(EDGES), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst(rst), .rst_n_in(rst_n_in), .bus_clk(bus_clk),
        .filt_rst_n(filt_rst_n), .rst_start(rst_start), .cmd_ready(cmd_ready)
    );

    // bus clock source, half period in reference cycles, 0 = stopped
    initial begin
        forever begin
            if (bus_half == 0) @(negedge clk);
            else begin
                repeat (bus_half) @(negedge clk);
                bus_clk = ~bus_clk;
                if (bus_clk) bus_edges++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_changes(input int w);
        return (w >= FILT) ? 2 : 0;
    endfunction

    function automatic int exp_starts(input int w);
        return (w >= FILT) ? 1 : 0;
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // cycles from an input change until filt_rst_n reaches target
    task automatic measure(input logic target, output int n);
        n = 0;
        do begin
            tick(); n++;
        end while (filt_rst_n != target && n < 10 * FILT);
    endtask

    // drive a pulse opposite to base for w cycles, then hold base; count effects
    task automatic pulse_run(input logic base, input int w, output int chg, output int st);
        logic prev;
        chg = 0; st = 0; prev = filt_rst_n;
        @(negedge clk); rst_n_in = ~base;
        for (int i = 0; i < w; i++) begin
            tick();
            if (filt_rst_n != prev) chg++;
            prev = filt_rst_n; st += int'(rst_start);
        end
        @(negedge clk); rst_n_in = base;
        for (int i = 0; i < 3 * FILT + 6; i++) begin
            tick();
            if (filt_rst_n != prev) chg++;
            prev = filt_rst_n; st += int'(rst_start);
        end
    endtask

    initial begin
        int n, chg, st, bad;
        logic base;
        void'($urandom(32'd20240611));

        repeat (5) @(posedge clk);
        #1;
        check(filt_rst_n == 0 && rst_start == 0 && cmd_ready == 0, "R8 in reset",
              {filt_rst_n, rst_start, cmd_ready}, 0);
        @(negedge clk); rst = 1'b0;
        tick();
        check(filt_rst_n == 0 && rst_start == 0 && cmd_ready == 0, "R8 after reset",
              {filt_rst_n, rst_start, cmd_ready}, 0);

        // first release with a fast bus clock: latency, strobe, hold-off
        bus_half = 2;
        @(negedge clk); rst_n_in = 1'b1;
        measure(1'b1, n);
        check(n == FILT + 2, "R2 rise latency", n, FILT + 2);
        check(rst_start == 1, "R4 strobe with rise", rst_start, 1);
        tick();
        check(rst_start == 0, "R4 strobe one cycle", rst_start, 0);
        repeat (LIMIT - 1) tick();
        check(cmd_ready == 0, "R6 not ready before hold-off", cmd_ready, 0);
        tick();
        check(cmd_ready == 1, "R6 ready at hold-off", cmd_ready, 1);

        // low glitches below the threshold keep level and readiness
        for (int k = 0; k < 6; k++) begin
            int w = (k == 0) ? FILT - 1 : (k == 1) ? 1 : $urandom_range(FILT - 1, 1);
            bad = 0;
            @(negedge clk); rst_n_in = 1'b0;
            repeat (w) begin tick(); if (!filt_rst_n || !cmd_ready) bad++; end
            @(negedge clk); rst_n_in = 1'b1;
            repeat (2 * FILT) begin tick(); if (!filt_rst_n || !cmd_ready) bad++; end
            check(bad == 0, (k == 1) ? "R3 one-cycle glitch" : "R1/R9 low glitch kept ready", bad, 0);
        end

        // accepted fall clears readiness in the same cycle, no strobe
        @(negedge clk); rst_n_in = 1'b0;
        measure(1'b0, n);
        check(n == FILT + 2, "R2 fall latency", n, FILT + 2);
        check(cmd_ready == 0, "R5 ready clears with fall", cmd_ready, 0);
        check(rst_start == 0, "R4 no strobe on fall", rst_start, 0);

        // slow bus clock: the 74th edge decides readiness
        bus_half = 0;
        repeat (8) tick();
        @(negedge clk); rst_n_in = 1'b1;
        measure(1'b1, n);
        check(rst_start == 1, "R4 strobe second rise", rst_start, 1);
        bus_edges = 0; bus_half = 20;
        n = 0;
        while (!cmd_ready && n < 20000) begin tick(); n++; end
        check(cmd_ready == 1, "R7 ready after slow bus", cmd_ready, 1);
        check(bus_edges == EDGES, "R7 bus edge count at ready", bus_edges, EDGES);
        check(n > LIMIT, "R6 slow case beyond hold-off", n, LIMIT);

        // stopped bus clock: readiness never comes
        @(negedge clk); rst_n_in = 1'b0;
        repeat (3 * FILT) tick();
        check(cmd_ready == 0 && filt_rst_n == 0, "R5 held low", cmd_ready, 0);
        bus_half = 0;
        repeat (8) tick();
        @(negedge clk); rst_n_in = 1'b1;
        repeat (3 * LIMIT) tick();
        check(cmd_ready == 0, "R7 stopped bus blocks ready", cmd_ready, 0);
        bus_half = 2;
        repeat (400) tick();
        check(cmd_ready == 1, "R7 ready once bus runs", cmd_ready, 1);

        // directed widths, then random widths on random base levels
        for (int k = 0; k < 30; k++) begin
            int w;
            string tag;
            if (k == 0)      w = FILT - 1;
            else if (k == 1) w = FILT;
            else if (k == 2) w = 250;
            else if (k == 3) w = 1;
            else             w = $urandom_range(2 * FILT, 1);
            if (k >= 4 && $urandom_range(1, 0) == 1) begin
                @(negedge clk); rst_n_in = ~rst_n_in;
                repeat (3 * FILT + 6) tick();
            end
            base = rst_n_in;
            pulse_run(base, w, chg, st);
            tag = (k == 2 || k == 3) ? "R3 default widths" : (w >= FILT) ? "R2 accepted pulse" : "R1 rejected pulse";
            check(chg == exp_changes(w), tag, chg, exp_changes(w));
            check(st == exp_starts(w), "R4 strobes per pulse", st, exp_starts(w));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule